// File: doc/BRIEF.md
# Wake-up Event Status Register

This block holds the 32-bit wake-up status word of a network controller. A host reads it over a simple single-register bus and writes it to acknowledge events. Three wake sources raise sticky flags: a change in link state, a received magic packet, and a received packet that matched the receive filters. Each flag stays set until the host writes a 1 to its bit. One bit reports, live, whether the on-chip management agent is busy.

The block also owns the power-management event (PME) status flag. Any wake source sets this flag, whatever the PME enable setting. The flag appears in the status word and also feeds the companion power-management control/status register, so clearing it through this word clears it there too. The PME output pin is driven while the flag is set and PME is enabled. A general wake flag for the card-bus function event register is also kept here. A write-one to the PME bit clears that flag only when card-bus mode is selected.

Only the alternate reset input initialises the block. The reset is synchronous and active low. Ordinary soft resets elsewhere in the controller leave the block unchanged.

Top module: `wake_status_reg`

## Requirements
- R1: After the alternate reset, the status word reads 0 and pme_status, pme_out and gen_wake are all 0. This holds with all event inputs held low.
- R2: Bit 31 (link change) is set the cycle after an ev_link strobe. It stays set until a write with wdata[31]=1 clears it.
- R3: Bit 30 (magic packet) is set the cycle after an ev_magic strobe, whatever the value of pme_en. A write with wdata[30]=1 clears it.
- R4: Bit 29 (filter match) is set the cycle after an ev_filter strobe. A write with wdata[29]=1 clears it.
- R5: Bit 25 reads the present value of mgmt_busy. Writes to bit 25 have no effect.
- R6: Bits 28:26 and 23:0 always read 0. Writes to them have no effect.
- R7: The PME flag is set the cycle after any wake strobe, whatever the value of pme_en. It reads in bit 24 and on pme_status, and a write with wdata[24]=1 clears it.
- R8: pme_out is 1 exactly when the PME flag is 1 and pme_en is 1.
- R9: gen_wake is set the cycle after any wake strobe. A write with wdata[24]=1 clears it only while cardbus_mode is 1; in any other mode it is kept.
- R10: When a strobe and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R11: Write data bits that are 0 leave the matching flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| alt_rst_n | input | 1 | Alternate reset, synchronous, active low |
| host_we | input | 1 | Host write strobe for the status word |
| host_wdata | input | 32 | Host write data; a 1 clears the matching flag |
| host_rdata | output | 32 | Present status word |
| ev_link | input | 1 | Link state changed (one-cycle strobe) |
| ev_magic | input | 1 | Magic packet received (one-cycle strobe) |
| ev_filter | input | 1 | Filter-matched packet received (one-cycle strobe) |
| mgmt_busy | input | 1 | Management agent busy level |
| pme_en | input | 1 | PME enable from the control/status register |
| cardbus_mode | input | 1 | Selects card-bus clear behaviour for gen_wake |
| pme_status | output | 1 | PME flag shared with the control/status register |
| pme_out | output | 1 | PME output pin |
| gen_wake | output | 1 | General wake flag for the function event register |

## Verification
Two cases are hard to produce from the ports. One is a strobe that arrives in the same cycle as a write-one clear of the same bit. The other is a PME clear while card-bus mode is off but gen_wake is set. The stimulus reaches both with directed sequences: a first event raises the flags, and the colliding strobe and write are then placed on one edge. A long run with biased random writes follows, with mode and enable toggled throughout, and a behavioural model checks every cycle.

// File: rtl/wk_pkg.sv
// Package: bit positions of the wake status word, shared by RTL and bench.
// Assumes a 32-bit host word; the positions are decoded by host software.
package wk_pkg;
    localparam int WORD_W    = 32;
    localparam int POS_LINK  = 31;
    localparam int POS_MAGIC = 30;
    localparam int POS_FILT  = 29;
    localparam int POS_BUSY  = 25;
    localparam int POS_PME   = 24;
    localparam int N_EVT     = 3;
    localparam logic [WORD_W-1:0] LIVE_MASK =
        (WORD_W'(1) << POS_LINK) | (WORD_W'(1) << POS_MAGIC) |
        (WORD_W'(1) << POS_FILT) | (WORD_W'(1) << POS_BUSY) |
        (WORD_W'(1) << POS_PME);
endpackage

// File: rtl/wk_sticky_bit.sv
// Module: one sticky flag. A strobe sets it and a write-one clears it; the set wins.
// Assumes set and clr are single-cycle qualified pulses. Reset is synchronous, active low.
module wk_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Holds the flag: reset, then set priority, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/wk_pme_ctl.sv
// Module: PME flag, the PME pin and the general wake flag.
// Assumes wake_i is the OR of the event strobes and pme_clr_i is a write-one to the PME bit.
module wk_pme_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic pme_clr_i,
    input  logic pme_en_i,
    input  logic cardbus_i,
    output logic pme_flag_o,
    output logic pme_pin_o,
    output logic gen_wake_o
);
    logic gen_clr;

    // The general wake flag is cleared only in card-bus mode.
    always_comb gen_clr = pme_clr_i && cardbus_i;

    // Holds the PME flag; wake events win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         pme_flag_o <= 1'b0;
        else if (wake_i)    pme_flag_o <= 1'b1;
        else if (pme_clr_i) pme_flag_o <= 1'b0;
    end

    // Holds the general wake flag; wake events win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       gen_wake_o <= 1'b0;
        else if (wake_i)  gen_wake_o <= 1'b1;
        else if (gen_clr) gen_wake_o <= 1'b0;
    end

    // Drives the pin from the flag, gated by the enable.
    always_comb pme_pin_o = pme_flag_o && pme_en_i;

    // R7
    pme_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> pme_flag_o);
    // R9
    gen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cardbus_i && gen_wake_o) |=> gen_wake_o);
    // R8
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_en_i |-> !pme_pin_o);
endmodule

// File: rtl/wake_status_reg.sv
// Module: top of the wake-up status word. Three sticky event bits, live busy bit, PME control.
// Assumes one register on the host bus (no address), reads are combinational,
// and alt_rst_n is the only reset that reaches this block.
module wake_status_reg
    import wk_pkg::*;
(
    input  logic              clk,
    input  logic              alt_rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              ev_link,
    input  logic              ev_magic,
    input  logic              ev_filter,
    input  logic              mgmt_busy,
    input  logic              pme_en,
    input  logic              cardbus_mode,
    output logic              pme_status,
    output logic              pme_out,
    output logic              gen_wake
);
    localparam int EVT_POS [N_EVT] = '{POS_LINK, POS_MAGIC, POS_FILT};

    logic [N_EVT-1:0] evt_set;
    logic [N_EVT-1:0] evt_q;
    logic [WORD_W-1:0] w1c;
    logic any_wake;

    // Qualifies write data into per-bit clear pulses.
    always_comb w1c = host_we ? host_wdata : '0;

    // Gathers the event strobes into one vector and an any-wake pulse.
    always_comb begin
        evt_set  = {ev_filter, ev_magic, ev_link};
        any_wake = |evt_set;
    end

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        wk_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (alt_rst_n),
            .set_i (evt_set[i]),
            .clr_i (w1c[EVT_POS[i]]),
            .q_o   (evt_q[i])
        );
    end

    wk_pme_ctl u_pme (
        .clk        (clk),
        .rst_n      (alt_rst_n),
        .wake_i     (any_wake),
        .pme_clr_i  (w1c[POS_PME]),
        .pme_en_i   (pme_en),
        .cardbus_i  (cardbus_mode),
        .pme_flag_o (pme_status),
        .pme_pin_o  (pme_out),
        .gen_wake_o (gen_wake)
    );

    // Assembles the read word; unused positions stay zero.
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < N_EVT; i++) host_rdata[EVT_POS[i]] = evt_q[i];
        host_rdata[POS_BUSY] = mgmt_busy;
        host_rdata[POS_PME]  = pme_status;
    end

    // R6
    resv_zero_chk: assert property (@(posedge clk) disable iff (!alt_rst_n)
        (host_rdata & ~LIVE_MASK) == '0);
    // R3
    magic_set_chk: assert property (@(posedge clk) disable iff (!alt_rst_n)
        ev_magic |=> host_rdata[POS_MAGIC]);
    // R2
    link_clr_chk: assert property (@(posedge clk) disable iff (!alt_rst_n)
        (host_we && host_wdata[POS_LINK] && !ev_link) |=> !host_rdata[POS_LINK]);
endmodule

// File: tb/wake_status_reg_bench.sv
// Bench: behavioural reference model updated each edge, compared each cycle at the falling edge.
module wake_status_reg_bench;
    import wk_pkg::*;

    logic clk = 1'b0;
    logic alt_rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic ev_link = 0, ev_magic = 0, ev_filter = 0;
    logic mgmt_busy = 0, pme_en = 0, cardbus_mode = 0;
    logic pme_status, pme_out, gen_wake;

    int n_chk = 0;
    int n_bad = 0;
    bit m_link, m_magic, m_filt, m_pme, m_gen;

    always #10 clk = ~clk;

    wake_status_reg u_wake_status_reg (
        .clk(clk), .alt_rst_n(alt_rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ev_link(ev_link), .ev_magic(ev_magic),
        .ev_filter(ev_filter), .mgmt_busy(mgmt_busy), .pme_en(pme_en),
        .cardbus_mode(cardbus_mode), .pme_status(pme_status), .pme_out(pme_out),
        .gen_wake(gen_wake));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compares every observable output with the model.
    task automatic compare_all();
        logic [31:0] exp_word;
        exp_word = '0;
        exp_word[31] = m_link; exp_word[30] = m_magic; exp_word[29] = m_filt;
        exp_word[25] = mgmt_busy; exp_word[24] = m_pme;
        chk("R2 link bit",   32'(host_rdata[31]), 32'(m_link));
        chk("R3 magic bit",  32'(host_rdata[30]), 32'(m_magic));
        chk("R4 filter bit", 32'(host_rdata[29]), 32'(m_filt));
        chk("R5 busy bit",   32'(host_rdata[25]), 32'(mgmt_busy));
        chk("R6 reserved",   host_rdata & 32'h1C_FFFFFF, 32'h0);
        chk("R7 pme bit",    32'(host_rdata[24]), 32'(m_pme));
        chk("R7 pme_status", 32'(pme_status), 32'(m_pme));
        chk("R8 pme_out",    32'(pme_out), 32'(m_pme && pme_en));
        chk("R9 gen_wake",   32'(gen_wake), 32'(m_gen));
        chk("R11 word",      host_rdata, exp_word);
    endtask

    // Advances one clock: updates the model at the edge, compares at the falling edge.
    task automatic step();
        logic [31:0] w;
        bit any;
        @(posedge clk);
        w = host_we ? host_wdata : '0;
        any = ev_link || ev_magic || ev_filter;
        if (!alt_rst_n) begin
            m_link = 0; m_magic = 0; m_filt = 0; m_pme = 0; m_gen = 0;
        end else begin
            m_link  = ev_link   ? 1 : (w[31] ? 0 : m_link);
            m_magic = ev_magic  ? 1 : (w[30] ? 0 : m_magic);
            m_filt  = ev_filter ? 1 : (w[29] ? 0 : m_filt);
            m_pme   = any ? 1 : (w[24] ? 0 : m_pme);
            m_gen   = any ? 1 : ((w[24] && cardbus_mode) ? 0 : m_gen);
        end
        @(negedge clk);
        compare_all();
        host_we = 0; host_wdata = '0; ev_link = 0; ev_magic = 0; ev_filter = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        host_we = 1; host_wdata = d;
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                repeat (3) step();
                // R1: reset state
                chk("R1 reset word", host_rdata, 32'h0);
                chk("R1 reset pins", {29'h0, pme_status, pme_out, gen_wake}, 32'h0);
                alt_rst_n = 1;
                step();
                // R3: magic captured with PME disabled; R8 pin stays low
                ev_magic = 1; step();
                chk("R3 magic with pme_en=0", 32'(host_rdata[30]), 32'h1);
                chk("R8 pin low while disabled", 32'(pme_out), 32'h0);
                pme_en = 1; step();
                chk("R8 pin high when enabled", 32'(pme_out), 32'h1);
                // R11: write of zeros keeps flags
                wr(32'h0000_0000); step();
                // R6, R5: write to reserved and busy positions has no effect
                mgmt_busy = 1; wr(32'h1EFF_FFFF); step();
                chk("R6 reserved after write", host_rdata & 32'h1C_FFFFFF, 32'h0);
                // R9: PME clear without card-bus keeps gen_wake
                cardbus_mode = 0; wr(32'h0100_0000); step();
                chk("R9 gen kept outside card-bus", 32'(gen_wake), 32'h1);
                chk("R7 pme cleared", 32'(pme_status), 32'h0);
                ev_link = 1; step();
                cardbus_mode = 1; wr(32'h0100_0000); step();
                chk("R9 gen cleared in card-bus", 32'(gen_wake), 32'h0);
                // R10: strobe and clear on the same edge
                ev_filter = 1; step();
                ev_filter = 1; wr(32'h2100_0000); step();
                chk("R10 filter set wins", 32'(host_rdata[29]), 32'h1);
                chk("R10 pme set wins", 32'(pme_status), 32'h1);
                wr(32'hE100_0000); step();
                chk("R2 R4 cleared", host_rdata & 32'hE100_0000, 32'h0);
                // Random run
                for (int k = 0; k < 4000; k++) begin
                    int r;
                    r = $urandom_range(0, 99);
                    ev_link   = ($urandom_range(0, 9) == 0);
                    ev_magic  = ($urandom_range(0, 9) == 0);
                    ev_filter = ($urandom_range(0, 9) == 0);
                    mgmt_busy = $urandom_range(0, 1);
                    if ($urandom_range(0, 15) == 0) pme_en = ~pme_en;
                    if ($urandom_range(0, 15) == 0) cardbus_mode = ~cardbus_mode;
                    if (r < 30) wr($urandom());
                    if (k == 2000) alt_rst_n = 0;
                    if (k == 2003) alt_rst_n = 1;
                    step();
                end
            end
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule